// File: doc/BRIEF.md
# Sync Frequency Measurement Counter

This block measures how far apart the sync pulses of an incoming display signal are. It times the horizontal and the vertical sync against tick streams that it derives from its own oscillator clock. It reports one horizontal and one vertical period count, each paired with a valid flag. At the nominal 12 MHz oscillator, the horizontal count is about 128 counts per microsecond of line period, taken over 16 lines. The vertical count is the number of 62.5 kHz ticks in one frame.

A higher sync frequency gives a smaller count. Firmware reads the two counts and maps them to a display mode. Each count register changes only when a measurement period closes or when its counter runs out of range. A reader therefore never sees a partial count. A period that is too long for the counter width reads as all ones, with the valid flag cleared.

Top module: `sync_freq_meter`

## Requirements
- R1: While reset is high, and after reset until the first report, both count outputs are zero and both valid flags are low.
- R2: Each sync input passes through a two-flop synchroniser. Only its low-to-high transitions are used, so the pulse width and duty cycle of the sync have no effect on the results.
- R3: The horizontal boundary is every 16th rising edge of the horizontal sync. The first rising edge after reset is a boundary. The time base ticks on 2 of every 3 clocks. For N clocks between boundaries, the 14-bit result is floor(2N/3) or ceil(2N/3). At 12 MHz this gives about 128 counts per microsecond of line period: 31.5 kHz reads about 4063 and 106.3 kHz reads about 1204.
- R4: Every rising edge of the vertical sync is a boundary. The time base ticks once per V_DEN clocks (192 by default, which is 62.5 kHz at 12 MHz). For N clocks between edges, the 12-bit result is floor(N/V_DEN) or ceil(N/V_DEN). At 12 MHz, 60 Hz reads about 1041 and 85 Hz reads about 735.
- R5: The first boundary after reset only starts a measurement. The valid flag stays low and the count stays at its reset value.
- R6: A count output and its valid flag change only at a boundary or at an overflow. In the middle of a period they hold the last result.
- R7: When the running count reaches all ones (16383 horizontal, 4095 vertical) before a boundary, the output becomes all ones at once and its valid flag goes low. A valid result is never all ones.
- R8: The boundary that closes an overflowed period reports all ones with valid low. The next period is measured and reported as valid again.
- R9: If the tick that would bring the count to all ones falls in the same cycle as a boundary, the report is all ones with valid low. A total of one less than all ones is reported as valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (12 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Asynchronous horizontal sync |
| vsync_in | input | 1 | Asynchronous vertical sync |
| h_period | output | 14 | Horizontal period count over 16 lines |
| h_valid | output | 1 | Horizontal count is a complete in-range measurement |
| v_period | output | 12 | Vertical period count over one frame |
| v_valid | output | 1 | Vertical count is a complete in-range measurement |

## Verification
A boundary and the tick that would carry the count to all ones can fall in the same cycle. The boundary then has to report saturation rather than a count. The bench provokes this by stretching the last line of a group so that the tick total sits one below, exactly at, and one above the all-ones limit. At the exact limit, the tick phase decides whether the boundary or the overflow comes first. The bench accepts either of the two legal outcomes there: a valid count one below the limit, or all ones with valid low. Outside that case it demands the single legal result.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    // Measurement phase of one channel: waiting for the first boundary, or timing a period.
    typedef enum logic {
        PH_SEEK    = 1'b0,
        PH_MEASURE = 1'b1
    } phase_e;

    // Per-cycle events that a channel hands to its period counter.
    typedef struct packed {
        logic tick;   // time-base tick
        logic bound;  // period boundary (qualified sync edge)
    } chan_evt_t;

    // Width of the fractional accumulator for a NUM/DEN tick rate.
    function automatic int unsigned acc_bits(input int unsigned num, input int unsigned den);
        return $clog2(num + den + 1);
    endfunction

    // Width of the edge-group counter for a given line count.
    function automatic int unsigned grp_bits(input int unsigned lines);
        return (lines < 2) ? 1 : $clog2(lines);
    endfunction

endpackage

// File: rtl/sfm_sync_edge.sv
module sfm_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lead
);
    // STAGES synchroniser flops followed by one history flop for edge detection.
    logic [STAGES:0] pipe;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= 1'b0;
                else     pipe[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[i] <= 1'b0;
                else     pipe[i] <= pipe[i-1];
            end
        end
    end

    // Rising edge of the synchronised level.
    assign lead = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/sfm_tick_gen.sv
module sfm_tick_gen import sfm_pkg::*; #(
    parameter int unsigned NUM = 2,
    parameter int unsigned DEN = 3
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned AW = acc_bits(NUM, DEN);

    if (NUM >= DEN) begin : g_every
        // Rate of one or more: tick on every clock.
        assign tick = 1'b1;
    end else begin : g_frac
        logic [AW-1:0] acc;
        logic [AW-1:0] sum;
        logic          wrap;

        assign sum  = acc + AW'(NUM);
        assign wrap = (sum >= AW'(DEN));
        assign tick = wrap;

        always_ff @(posedge clk) begin
            if (rst)       acc <= '0;
            else if (wrap) acc <= sum - AW'(DEN);
            else           acc <= sum;
        end
    end

endmodule

// File: rtl/sfm_period_ctr.sv
module sfm_period_ctr import sfm_pkg::*; #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  chan_evt_t    evt,
    output logic [W-1:0] value,
    output logic         valid
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] TOP  = ALL1 - W'(1);

    phase_e       phase;
    logic [W-1:0] cnt;
    logic         ovf;
    logic         last_tick;
    logic         close_sat;

    // The tick that would bring the count to all ones.
    assign last_tick = evt.tick && !ovf && (cnt == TOP);
    // A period closing now is out of range.
    assign close_sat = ovf || last_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SEEK;
            cnt   <= '0;
            ovf   <= 1'b0;
            value <= '0;
            valid <= 1'b0;
        end else if (evt.bound) begin
            cnt   <= '0;
            ovf   <= 1'b0;
            phase <= PH_MEASURE;
            if (phase == PH_MEASURE) begin
                if (close_sat) begin
                    value <= ALL1;
                    valid <= 1'b0;
                end else begin
                    value <= cnt + W'(evt.tick);
                    valid <= 1'b1;
                end
            end
        end else if (last_tick) begin
            cnt   <= ALL1;
            ovf   <= 1'b1;
            value <= ALL1;
            valid <= 1'b0;
        end else if (evt.tick && !ovf) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/sfm_channel.sv
module sfm_channel import sfm_pkg::*; #(
    parameter int unsigned W      = 14,
    parameter int unsigned LINES  = 16,
    parameter int unsigned NUM    = 2,
    parameter int unsigned DEN    = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sync_in,
    output logic [W-1:0] value,
    output logic         valid,
    output chan_evt_t    evt
);
    localparam int unsigned GW = grp_bits(LINES);

    logic lead;
    logic tick;
    logic bound;

    sfm_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_in),
        .lead (lead)
    );

    sfm_tick_gen #(.NUM(NUM), .DEN(DEN)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    // Group LINES edges into one measurement period; the first edge after reset is a boundary.
    if (LINES < 2) begin : g_single
        assign bound = lead;
    end else begin : g_group
        logic [GW-1:0] ecnt;
        assign bound = lead && (ecnt == '0);
        always_ff @(posedge clk) begin
            if (rst)
                ecnt <= '0;
            else if (lead)
                ecnt <= (ecnt == GW'(LINES - 1)) ? '0 : ecnt + GW'(1);
        end
    end

    assign evt.tick  = tick;
    assign evt.bound = bound;

    sfm_period_ctr #(.W(W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .value (value),
        .valid (valid)
    );

endmodule

// File: rtl/sync_freq_meter.sv
module sync_freq_meter import sfm_pkg::*; #(
    parameter int unsigned H_WIDTH     = 14,
    parameter int unsigned V_WIDTH     = 12,
    parameter int unsigned H_LINES     = 16,
    parameter int unsigned H_NUM       = 2,
    parameter int unsigned H_DEN       = 3,
    parameter int unsigned V_NUM       = 1,
    parameter int unsigned V_DEN       = 192,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hsync_in,
    input  logic               vsync_in,
    output logic [H_WIDTH-1:0] h_period,
    output logic               h_valid,
    output logic [V_WIDTH-1:0] v_period,
    output logic               v_valid
);
    chan_evt_t h_evt;
    chan_evt_t v_evt;
    logic      h_bound;
    logic      h_tick;
    logic      v_bound;
    logic      v_tick;

    sfm_channel #(
        .W(H_WIDTH), .LINES(H_LINES), .NUM(H_NUM), .DEN(H_DEN), .STAGES(SYNC_STAGES)
    ) u_hchan (
        .clk     (clk),
        .rst     (rst),
        .sync_in (hsync_in),
        .value   (h_period),
        .valid   (h_valid),
        .evt     (h_evt)
    );

    sfm_channel #(
        .W(V_WIDTH), .LINES(1), .NUM(V_NUM), .DEN(V_DEN), .STAGES(SYNC_STAGES)
    ) u_vchan (
        .clk     (clk),
        .rst     (rst),
        .sync_in (vsync_in),
        .value   (v_period),
        .valid   (v_valid),
        .evt     (v_evt)
    );

    assign h_bound = h_evt.bound;
    assign h_tick  = h_evt.tick;
    assign v_bound = v_evt.bound;
    assign v_tick  = v_evt.tick;

endmodule

// File: rtl/sfm_checks.sv
module sfm_checks #(
    parameter int unsigned H_WIDTH = 14,
    parameter int unsigned V_WIDTH = 12,
    parameter int unsigned H_NUM   = 2,
    parameter int unsigned H_DEN   = 3,
    parameter int unsigned V_NUM   = 1,
    parameter int unsigned V_DEN   = 192
) (
    input logic               clk,
    input logic               rst,
    input logic [H_WIDTH-1:0] h_period,
    input logic               h_valid,
    input logic [V_WIDTH-1:0] v_period,
    input logic               v_valid,
    input logic               h_bound,
    input logic               h_tick,
    input logic               v_bound,
    input logic               v_tick
);
    // R7: a valid result is never the saturated value.
    assert_h_valid_below_max_R7: assert property (@(posedge clk) disable iff (rst)
        h_valid |-> (h_period != {H_WIDTH{1'b1}}));
    assert_v_valid_below_max_R7: assert property (@(posedge clk) disable iff (rst)
        v_valid |-> (v_period != {V_WIDTH{1'b1}}));

    // R7 / R8: losing validity always leaves the saturated value behind.
    assert_h_drop_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(h_valid) && !$past(rst)) |-> (h_period == {H_WIDTH{1'b1}}));
    assert_v_drop_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(v_valid) && !$past(rst)) |-> (v_period == {V_WIDTH{1'b1}}));

    // R6: a valid result only changes to another valid one at a boundary.
    assert_h_update_at_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && h_valid && $past(h_valid) && (h_period != $past(h_period)))
            |-> $past(h_bound));
    assert_v_update_at_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && v_valid && $past(v_valid) && (v_period != $past(v_period)))
            |-> $past(v_bound));

    // R5 / R6: validity is only gained at a boundary.
    assert_h_rise_at_bound_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(h_valid) && !$past(rst)) |-> $past(h_bound));
    assert_v_rise_at_bound_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(v_valid) && !$past(rst)) |-> $past(v_bound));

    // R3 / R4: tick spacing follows the fractional rate.
    if (3 * H_NUM <= 2 * H_DEN) begin : g_htick
        assert_h_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
            (h_tick && $past(h_tick) && !$past(rst)) |-> !$past(h_tick, 2) || !h_tick);
    end
    if (2 * V_NUM <= V_DEN) begin : g_vtick
        assert_v_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
            v_tick |=> !v_tick);
    end

endmodule

bind sync_freq_meter sfm_checks #(
    .H_WIDTH(H_WIDTH), .V_WIDTH(V_WIDTH),
    .H_NUM(H_NUM), .H_DEN(H_DEN), .V_NUM(V_NUM), .V_DEN(V_DEN)
) u_checks (
    .clk      (clk),
    .rst      (rst),
    .h_period (h_period),
    .h_valid  (h_valid),
    .v_period (v_period),
    .v_valid  (v_valid),
    .h_bound  (h_bound),
    .h_tick   (h_tick),
    .v_bound  (v_bound),
    .v_tick   (v_tick)
);

// File: tb/sync_freq_meter_test.sv
`timescale 1ns/1ps
module sync_freq_meter_test;

    localparam int VD = 4;          // shortened vertical divider for run time
    localparam int HW = 14;
    localparam int VW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic [HW-1:0] h_period;
    logic          h_valid;
    logic [VW-1:0] v_period;
    logic          v_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int prev_n [2];   // 0: none yet, -1: saturated expected, else clocks in closed period
    int seen   [2];

    always #2 clk = ~clk;

    sync_freq_meter #(.V_DEN(VD)) uut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .h_period(h_period), .h_valid(h_valid),
        .v_period(v_period), .v_valid(v_valid)
    );

    function automatic int get_val(input int ch);
        return (ch != 0) ? int'(v_period) : int'(h_period);
    endfunction

    function automatic bit get_vld(input int ch);
        return (ch != 0) ? v_valid : h_valid;
    endfunction

    task automatic report(input bit ok, input string req, input int got, input bit gotv,
                          input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got value %0d valid %0b, expected %s", req, got, gotv, exp);
        end
    endtask

    // Expected result for a closed period of n clocks (R3, R4, R7, R9).
    task automatic check_meas(input int ch, input int n, input string req);
        int w   = (ch != 0) ? VW : HW;
        int num = (ch != 0) ? 1 : 2;
        int den = (ch != 0) ? VD : 3;
        int mx  = (1 << w) - 1;
        int lo  = (n * num) / den;
        int hi  = (n * num + den - 1) / den;
        int got = get_val(ch);
        bit v   = get_vld(ch);
        bit ok;
        if (lo >= mx)
            ok = (got == mx) && !v;
        else if (hi < mx)
            ok = v && (got >= lo) && (got <= hi);
        else
            ok = (v && got == lo) || (!v && got == mx);
        report(ok, req, got, v, $sformatf("%0d..%0d (sat at %0d)", lo, hi, mx));
    endtask

    task automatic check_bound(input int ch);
        int mx = (1 << ((ch != 0) ? VW : HW)) - 1;
        if (prev_n[ch] == 0)
            report(!get_vld(ch) && get_val(ch) == 0, "R5", get_val(ch), get_vld(ch), "0 invalid");
        else if (prev_n[ch] < 0)
            report(!get_vld(ch) && get_val(ch) == mx, "R8", get_val(ch), get_vld(ch),
                   $sformatf("%0d invalid", mx));
        else
            check_meas(ch, prev_n[ch], (ch != 0) ? "R4 R2 R9" : "R3 R2 R9");
        seen[ch] = get_val(ch);
    endtask

    // One sync line of len clocks, high for hi clocks; optional checks inside.
    task automatic line(input int ch, input int len, input int hi, input bit bnd, input bit stab,
                        input bit sat_end);
        int mx = (1 << ((ch != 0) ? VW : HW)) - 1;
        if (ch != 0) vsync_in = 1'b1; else hsync_in = 1'b1;
        for (int c = 0; c < len; c++) begin
            if (c == hi) begin
                if (ch != 0) vsync_in = 1'b0; else hsync_in = 1'b0;
            end
            if (c == 8 && bnd) check_bound(ch);
            if (c == len / 2 && stab)
                report(get_val(ch) == seen[ch], "R6", get_val(ch), get_vld(ch),
                       $sformatf("held %0d", seen[ch]));
            if (c == len - 10 && sat_end)
                report(!get_vld(ch) && get_val(ch) == mx, "R7", get_val(ch), get_vld(ch),
                       $sformatf("%0d invalid", mx));
            @(negedge clk);
        end
    endtask

    task automatic group(input int ch, input int p, input int extra);
        int nl = (ch != 0) ? 1 : 16;
        for (int i = 0; i < nl; i++) begin
            int len = p + ((i == nl - 1) ? extra : 0);
            int hi  = int'($urandom_range(len - 3, 3));
            line(ch, len, hi, i == 0, i == nl / 2, 1'b0);
        end
        prev_n[ch] = nl * p + extra;
    endtask

    task automatic lost_sync(input int ch);
        int nl  = (ch != 0) ? 1 : 16;
        int len = (ch != 0) ? 16600 : 25000;
        line(ch, len, 10, 1'b1, 1'b0, 1'b1);
        for (int i = 1; i < nl; i++) line(ch, 200, 50, 1'b0, 1'b0, 1'b0);
        prev_n[ch] = -1;
    endtask

    task automatic run_chan(input int ch);
        group(ch, 200, 0);                                   // R5 arm
        group(ch, (ch != 0) ? 1700 : 381, 0);                // 31.5 kHz-like line
        group(ch, (ch != 0) ? 900 : 113, 0);                 // 106.3 kHz-like line
        for (int k = 0; k < 5; k++)
            group(ch, (ch != 0) ? int'($urandom_range(4000, 400)) : int'($urandom_range(400, 120)), 0);
        // R9 threshold: one below, straddling, and at the limit
        if (ch != 0) begin
            group(ch, 16376, 0);
            group(ch, 16379, 0);
            group(ch, 16380, 0);
        end else begin
            group(ch, 1535, 13);
            group(ch, 1535, 14);
            group(ch, 1535, 15);
        end
        lost_sync(ch);                                       // R7
        group(ch, 200, 0);                                   // R8 saturated report
        group(ch, 200, 0);                                   // R8 recovery
        line(ch, 200, 60, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd5150));
        prev_n[0] = 0; prev_n[1] = 0;
        seen[0] = 0;   seen[1] = 0;
        repeat (4) @(negedge clk);
        report(h_period == 0 && !h_valid, "R1", int'(h_period), h_valid, "0 invalid");
        report(v_period == 0 && !v_valid, "R1", int'(v_period), v_valid, "0 invalid");
        rst = 1'b0;
        repeat (6) @(negedge clk);
        report(h_period == 0 && !h_valid && v_period == 0 && !v_valid, "R1",
               int'(h_period), h_valid, "0 invalid on both");
        fork
            run_chan(0);
            run_chan(1);
        join
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected run to end");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule